// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides the system clock down to a single-cycle enable pulse that marks each sample point of a 16x-oversampling serial receiver and transmitter. The division ratio is a 16-bit binary divisor, chosen as `f_clk / (baud * 16)`. A host writes it one byte at a time into two latches, the low byte at write address 0 and the high byte at write address 1. A down-counter is loaded from the divisor, steps down once per clock and raises the sample pulse when it reaches one. It then reloads itself.

A host write to either byte does not wait for the running count to expire. On the same clock edge that stores the byte, the counter is loaded with the merged new divisor. Software can therefore retune the rate and get a known phase at once. A second output divides the sample pulse by the oversampling ratio to give a once-per-bit strobe, and that strobe's phase restarts at every divisor write. Both latches clear on reset. While the divisor is zero the block produces no pulses, so the generator stays quiet until it is programmed.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset is released, and before any write, `tick_16x` and `baud_tick` are both 0 on every cycle.
- R2: A write with `wr_en`=1 and `wr_addr`=0 stores `wr_data` as divisor bits 7:0. A write with `wr_addr`=1 stores it as divisor bits 15:8. The other byte keeps its value.
- R3: With a divisor N ≥ 2 and no further writes, `tick_16x` is a one-cycle pulse that repeats exactly every N clock cycles.
- R4: With a divisor of 1, `tick_16x` is 1 on every clock cycle.
- R5: With a divisor of 0, `tick_16x` and `baud_tick` stay 0.
- R6: A write to either latch reloads the counter on the write's own clock edge. Counting the first rising edge after that write edge as edge 1, the first `tick_16x` is high in the cycle after edge N−1 (for N = 1, in the cycle right after the write edge). This holds whatever the earlier count was.
- R7: `baud_tick` is high only together with `tick_16x`, and exactly on every 16th `tick_16x` pulse counted from the most recent divisor write.
- R8: While `wr_en` is 0, changes on `wr_addr` and `wr_data` have no effect on the pulse pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that is divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for a divisor byte |
| wr_addr | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Divisor byte to store |
| tick_16x | output | 1 | One-cycle pulse at 16x the baud rate |
| baud_tick | output | 1 | One-cycle pulse at the baud rate |

## Verification
The bench targets the phase after a write. If a design let the old count run out before reloading, the first pulse after retuning from a divisor of 200 to 5 would arrive far too late. If it reloaded one edge later than the write, every pulse would sit one cycle late. A divisor of 1 is covered because a design that counts down to zero before reloading would halve the rate there. A divisor of 0 is covered because a counter that wraps would pulse every 65536 cycles, or constantly. Divisors with a nonzero high byte catch a design that drops or swaps a byte, and the sixteenth-pulse check at divisor 2 catches a per-bit strobe that is off by one pulse or that keeps its phase across writes.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   // Default geometry of the generator.
   localparam int unsigned DEF_DIV_W      = 16;
   localparam int unsigned DEF_BYTE_W     = 8;
   localparam int unsigned DEF_OVERSAMPLE = 16;

   // Address width needed to select one of n byte lanes, at least one bit.
   function automatic int unsigned lane_addr_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_BYTES = DIV_W / BYTE_W,
   parameter int unsigned ADDR_W    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  div_q,
   output logic [DIV_W-1:0]  div_next,
   output logic              load
);

   logic [NUM_BYTES-1:0] hit;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q[g*BYTE_W +: BYTE_W] <= '0;
         end else if (hit[g]) begin
            div_q[g*BYTE_W +: BYTE_W] <= wr_data;
         end
      end

      // Merged value the counter takes on the write edge itself.
      assign div_next[g*BYTE_W +: BYTE_W] = hit[g] ? wr_data : div_q[g*BYTE_W +: BYTE_W];
   end

   assign load = |hit;

endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] load_val,
   input  logic [DIV_W-1:0] div_q,
   output logic [DIV_W-1:0] cnt,
   output logic             tick
);

   localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
   localparam logic [DIV_W-1:0] ZERO = '0;

   logic at_one;
   logic idle;

   assign at_one = (cnt == ONE);
   assign idle   = (cnt == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ZERO;
      end else if (load) begin
         cnt <= load_val;
      end else if (at_one) begin
         cnt <= div_q;
      end else if (!idle) begin
         cnt <= cnt - ONE;
      end
   end

   assign tick = at_one;

endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen #(
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          ENABLE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic strobe
);

   localparam int unsigned SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [SUB_W-1:0] LAST = SUB_W'(OVERSAMPLE - 1);

   if (ENABLE) begin : g_on
      logic [SUB_W-1:0] sub;
      logic             wrap;

      assign wrap = (sub == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sub <= '0;
         end else if (clear) begin
            sub <= '0;
         end else if (tick) begin
            sub <= wrap ? '0 : sub + SUB_W'(1);
         end
      end

      assign strobe = tick && wrap;
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, clear, tick};
      assign strobe    = 1'b0;
   end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned DIV_W      = DEF_DIV_W,
   parameter int unsigned BYTE_W     = DEF_BYTE_W,
   parameter int unsigned OVERSAMPLE = DEF_OVERSAMPLE,
   parameter bit          STROBE_EN  = 1'b1,
   localparam int unsigned NUM_BYTES = DIV_W / BYTE_W,
   localparam int unsigned ADDR_W    = lane_addr_w(DIV_W / BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick_16x,
   output logic              baud_tick
);

   if ((DIV_W % BYTE_W) != 0 || DIV_W < BYTE_W) begin : g_bad_width
      $error("baud_rate_gen: DIV_W must be a whole multiple of BYTE_W");
   end
   if (OVERSAMPLE < 2) begin : g_bad_ovs
      $error("baud_rate_gen: OVERSAMPLE must be at least 2");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_next;
   logic             load;
   logic [DIV_W-1:0] cnt;

   baud_div_latch #(
      .DIV_W     (DIV_W),
      .BYTE_W    (BYTE_W),
      .NUM_BYTES (NUM_BYTES),
      .ADDR_W    (ADDR_W)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .div_q    (div_q),
      .div_next (div_next),
      .load     (load)
   );

   baud_down_counter #(
      .DIV_W (DIV_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (div_next),
      .div_q    (div_q),
      .cnt      (cnt),
      .tick     (tick_16x)
   );

   baud_strobe_gen #(
      .OVERSAMPLE (OVERSAMPLE),
      .ENABLE     (STROBE_EN)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (load),
      .tick   (tick_16x),
      .strobe (baud_tick)
   );

endmodule

module baud_rate_gen_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [DIV_W-1:0] div_q,
   input logic [DIV_W-1:0] cnt,
   input logic             tick_16x,
   input logic             baud_tick
);

   p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) |-> (!tick_16x && !baud_tick));

   p_div_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == DIV_W'(1)) |-> tick_16x);

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == div_q));

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_16x && (div_q > DIV_W'(1)) && !wr_en) |=> !tick_16x);

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_q);

   p_strobe_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> tick_16x);

endmodule

bind baud_rate_gen baud_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .div_q     (div_q),
   .cnt       (cnt),
   .tick_16x  (tick_16x),
   .baud_tick (baud_tick)
);

// File: tb/tb_baud_rate_gen.sv
module tb_baud_rate_gen;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 9;
   // Divisors walked by the main loop; high byte nonzero in two entries.
   localparam logic [15:0] VEC [NVEC] = '{16'd2, 16'd3, 16'd5, 16'd7, 16'd16,
                                          16'h0100, 16'h0103, 16'd1, 16'd4};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [0:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick_16x;
   logic       baud_tick;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_rate_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tick_16x  (tick_16x),
      .baud_tick (baud_tick)
   );

   task automatic chk(input string req, input logic act, input logic exp, input int idx);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s sample %0d: actual %b expected %b", req, idx, act, exp);
      end
   endtask

   // Ends at the falling edge right after the write edge (sample index 0).
   task automatic write_byte(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Compare len samples against the pattern of divisor n counted from the last write.
   task automatic watch(input int n, input int len, input string req, input bool_noise);
      for (int k = 0; k < len; k++) begin
         logic exp_t, exp_s;
         exp_t = (n != 0) && (((k + 1) % n) == 0);
         exp_s = exp_t && ((((k + 1) / n) % 16) == 0);
         chk(req, tick_16x, exp_t, k);
         chk("R7", baud_tick, exp_s, k);
         if (bool_noise) begin
            wr_addr = ~wr_addr;
            wr_data = wr_data + 8'd37;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: nothing before any write
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R1", tick_16x, 1'b0, k);
         chk("R1", baud_tick, 1'b0, k);
      end

      // R2/R3/R4/R6: table of divisors, low byte then high byte
      for (int v = 0; v < NVEC; v++) begin
         write_byte(1'b0, VEC[v][7:0]);
         write_byte(1'b1, VEC[v][15:8]);
         watch(int'(VEC[v]), 3 * int'(VEC[v]) + 2,
               (VEC[v] == 16'd1) ? "R4" : ((VEC[v] > 16'd255) ? "R2" : "R3"), 1'b0);
      end

      // R7: sixteenth pulse at divisor 2
      write_byte(1'b1, 8'd0);
      write_byte(1'b0, 8'd2);
      watch(2, 70, "R7", 1'b0);

      // R6: low-byte write cuts a long count short
      write_byte(1'b0, 8'd200);
      watch(200, 50, "R6", 1'b0);
      write_byte(1'b0, 8'd5);
      watch(5, 12, "R6", 1'b0);

      // R6: high-byte write of an unchanged value still restarts the phase
      write_byte(1'b0, 8'd10);
      watch(10, 4, "R6", 1'b0);
      write_byte(1'b1, 8'd0);
      watch(10, 25, "R6", 1'b0);

      // R8: bus activity with wr_en low leaves the pattern alone
      write_byte(1'b0, 8'd4);
      watch(4, 40, "R8", 1'b1);

      // R5: zero divisor silences the outputs
      write_byte(1'b0, 8'd0);
      watch(0, 60, "R5", 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule